// File: doc/BRIEF.md
# Serial Port Host Register Bank

This block is the byte-wide register bank that a host processor sees on a PC-compatible serial port. A 3-bit offset with separate read and write strobes selects one of eight byte locations. Behind them sit the line control, modem control and scratch bytes, the FIFO enable bit, the interrupt enable nibble, a 16-bit baud divisor and a 16-entry receive byte queue. Bit timing is not handled here. Received bytes arrive on a one-cycle parallel strobe. Transmitted bytes leave on a valid/ready handshake.

A separate interrupt block sits next to this one and gets four single-cycle strobes from it. One marks a byte accepted into the queue. One marks a data write meant for transmit. One marks a data read that leaves the queue empty. One marks a read of the interrupt identification location. The interrupt block sends back a 4-bit identification code, which this block shows at offset 2. Setting the divisor-access bit of line control turns offsets 0 and 1 into the divisor bytes. Setting the loopback bit of modem control sends written data into the local receive queue instead of onto the outgoing handshake.

Top module: `uart_host_regs`

## Requirements
- R1: After a synchronous reset, every location reads 0x00 except line status, which reads 0x60. `txValid` is low, `divisor` is 0 and `ierOut` is 0.
- R2: While line control bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte. `divisor` outputs the full 16-bit value. In this mode the receive queue, the interrupt enable nibble and the transmit path are not touched.
- R3: Line control (offset 3), modem control (offset 4) and scratch (offset 7) read back the full byte last written to them.
- R4: A write to offset 1 with bit 7 of line control clear keeps only bits 3:0. Offset 1 then reads {4'b0000, nibble}, and the nibble also appears on `ierOut`.
- R5: A strobe on `rxValid` while the queue is not full stores `rxByte`, pulses `rxPushStrobe` in the same cycle and sets line status bit 0 (data ready).
- R6: Reads of offset 0 with bit 7 of line control clear return the queued bytes in arrival order and remove each one.
- R7: The queue holds 16 bytes. A byte that arrives while it is full is dropped without a `rxPushStrobe` pulse, and the 16 stored bytes stay intact and in order.
- R8: A read of offset 0 with an empty queue returns 0x00. Any data read that leaves the queue empty (no byte accepted in the same cycle) pulses `rxDrainStrobe` and clears data ready.
- R9: A data write to offset 0 pulses `txWriteStrobe`. With modem control bit 4 (loopback) clear, the byte is held on `txByte` with `txValid` high until a cycle with `txReady` high. With loopback set, the byte goes into the receive queue and `txValid` stays low.
- R10: Writes to offset 5 (line status) and offset 6 have no effect. Offset 6 always reads 0x00.
- R11: Reading offset 2 returns `intId` in bits 3:0 and zeros in bits 5:4. Bits 7:6 are 2'b11 when the FIFO enable bit (bit 0 of a write to offset 2) is set and 2'b00 otherwise. The read pulses `iirReadStrobe`, and the stored enable bit drives `fifoEnable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regAddr | input | 3 | Register offset |
| regWrEn | input | 1 | Write strobe |
| regRdEn | input | 1 | Read strobe (side effects at the clock edge) |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr`, combinational |
| rxValid | input | 1 | Received byte strobe |
| rxByte | input | 8 | Received byte |
| txReady | input | 1 | Consumer accepts `txByte` |
| txValid | output | 1 | Transmit byte pending |
| txByte | output | 8 | Transmit byte |
| intId | input | 4 | Interrupt identification code from the interrupt block |
| fifoEnable | output | 1 | Stored FIFO enable bit |
| ierOut | output | 4 | Interrupt enable nibble |
| divisor | output | 16 | Baud divisor |
| rxPushStrobe | output | 1 | A byte entered the receive queue |
| rxDrainStrobe | output | 1 | A data read left the queue empty |
| txWriteStrobe | output | 1 | A data write for transmit occurred |
| iirReadStrobe | output | 1 | Offset 2 was read |

## Verification
The bench sets the divisor-access bit and then reads and writes offsets 0 and 1. A decoder that ignored the bit would consume queue bytes or start a transmit instead of reaching the divisor. It fills the queue to 16 and sends a seventeenth byte. A queue that wrapped would overwrite the oldest entry, and one that miscounted would read back wrong or missing bytes. It reads an empty queue and checks that the drain strobe pulses only on the read that empties it. It runs the transmit path with and without loopback. A wrong loopback path would raise `txValid` or never set data ready.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int BYTE_W = 8;
  localparam int OFF_W  = 3;

  localparam logic [OFF_W-1:0] OFF_DATA = 3'd0;
  localparam logic [OFF_W-1:0] OFF_IER  = 3'd1;
  localparam logic [OFF_W-1:0] OFF_IIR  = 3'd2;
  localparam logic [OFF_W-1:0] OFF_LCR  = 3'd3;
  localparam logic [OFF_W-1:0] OFF_MCR  = 3'd4;
  localparam logic [OFF_W-1:0] OFF_LSR  = 3'd5;
  localparam logic [OFF_W-1:0] OFF_MSR  = 3'd6;
  localparam logic [OFF_W-1:0] OFF_SCR  = 3'd7;

  localparam int DIV_ACCESS_BIT = 7;
  localparam int LOOPBACK_BIT   = 4;

  typedef struct packed {
    logic wrDivLo;
    logic wrDivHi;
    logic wrIer;
    logic wrFcr;
    logic wrLcr;
    logic wrMcr;
    logic wrScr;
    logic wrThr;
    logic rdRbr;
    logic rdIir;
  } regStrobes_t;
endpackage

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full,
  output logic [$clog2(DEPTH):0] count
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] cnt;
  logic             doPush, doPop;

  assign empty  = (cnt == '0);
  assign full   = (cnt == CNT_W'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];
  assign count  = cnt;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH)) else $error("queue count beyond depth"); // R7

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (full && $stable(wrPtr) && $stable(rdPtr)))
    else $error("push into full queue moved pointers"); // R7

  AST_PUSH_GROW: assert property (@(posedge clk) disable iff (rst)
    (push && !full && !pop) |=> (cnt == $past(cnt) + CNT_W'(1)))
    else $error("accepted push did not grow queue"); // R5
endmodule

// File: rtl/uart_reg_ctrl.sv
module uart_reg_ctrl
  import uart_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OFF_W-1:0] regAddr,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic             divAccess,
  output regStrobes_t      strobes
);
  always_comb begin
    strobes = '0;
    if (regWrEn) begin
      case (regAddr)
        OFF_DATA: begin
          if (divAccess) strobes.wrDivLo = 1'b1;
          else           strobes.wrThr   = 1'b1;
        end
        OFF_IER: begin
          if (divAccess) strobes.wrDivHi = 1'b1;
          else           strobes.wrIer   = 1'b1;
        end
        OFF_IIR: strobes.wrFcr = 1'b1;
        OFF_LCR: strobes.wrLcr = 1'b1;
        OFF_MCR: strobes.wrMcr = 1'b1;
        OFF_SCR: strobes.wrScr = 1'b1;
        default: ;
      endcase
    end
    if (regRdEn) begin
      if (regAddr == OFF_DATA && !divAccess) strobes.rdRbr = 1'b1;
      if (regAddr == OFF_IIR)                strobes.rdIir = 1'b1;
    end
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.wrDivLo, strobes.wrDivHi, strobes.wrIer, strobes.wrFcr,
              strobes.wrLcr, strobes.wrMcr, strobes.wrScr, strobes.wrThr}))
    else $error("more than one register written"); // R3

  AST_DIV_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    divAccess |-> !(strobes.wrThr || strobes.rdRbr || strobes.wrIer))
    else $error("data path touched in divisor mode"); // R2
endmodule

// File: rtl/uart_reg_datapath.sv
module uart_reg_datapath
  import uart_regs_pkg::*;
#(
  parameter int QUEUE_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  regStrobes_t       strobes,
  input  logic [OFF_W-1:0]  regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txReady,
  output logic              txValid,
  output logic [BYTE_W-1:0] txByte,
  input  logic [3:0]        intId,
  output logic              divAccess,
  output logic              fifoEnable,
  output logic [3:0]        ierOut,
  output logic [15:0]       divisor,
  output logic              rxPushStrobe,
  output logic              rxDrainStrobe,
  output logic              txWriteStrobe,
  output logic              iirReadStrobe
);
  localparam int CNT_W = $clog2(QUEUE_DEPTH) + 1;

  logic [BYTE_W-1:0] lineCtrl, modemCtrl, scratch;
  logic [3:0]        intEnable;
  logic              fifoEn;
  logic [15:0]       divReg;
  logic              loopback;

  logic              qPush, qEmpty, qFull;
  logic [BYTE_W-1:0] qData, qHead;
  logic [CNT_W-1:0]  qCount;
  logic              accepted;

  assign divAccess = lineCtrl[DIV_ACCESS_BIT];
  assign loopback  = modemCtrl[LOOPBACK_BIT];

  always_comb begin
    if (strobes.wrThr && loopback) begin
      qPush = 1'b1;
      qData = regWrData;
    end else begin
      qPush = rxValid;
      qData = rxByte;
    end
  end

  assign accepted = qPush && !qFull;

  uart_rx_queue #(.WIDTH(BYTE_W), .DEPTH(QUEUE_DEPTH)) rxQueue (
    .clk      (clk),
    .rst      (rst),
    .push     (qPush),
    .pushData (qData),
    .pop      (strobes.rdRbr),
    .head     (qHead),
    .empty    (qEmpty),
    .full     (qFull),
    .count    (qCount)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lineCtrl  <= '0;
      modemCtrl <= '0;
      scratch   <= '0;
      intEnable <= '0;
      fifoEn    <= 1'b0;
      divReg    <= '0;
    end else begin
      if (strobes.wrLcr)   lineCtrl     <= regWrData;
      if (strobes.wrMcr)   modemCtrl    <= regWrData;
      if (strobes.wrScr)   scratch      <= regWrData;
      if (strobes.wrIer)   intEnable    <= regWrData[3:0];
      if (strobes.wrFcr)   fifoEn       <= regWrData[0];
      if (strobes.wrDivLo) divReg[7:0]  <= regWrData;
      if (strobes.wrDivHi) divReg[15:8] <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txValid <= 1'b0;
      txByte  <= '0;
    end else if (strobes.wrThr && !loopback) begin
      txValid <= 1'b1;
      txByte  <= regWrData;
    end else if (txValid && txReady) begin
      txValid <= 1'b0;
    end
  end

  always_comb begin
    case (regAddr)
      OFF_DATA: regRdData = divAccess ? divReg[7:0] : (qEmpty ? 8'h00 : qHead);
      OFF_IER:  regRdData = divAccess ? divReg[15:8] : {4'b0000, intEnable};
      OFF_IIR:  regRdData = {{2{fifoEn}}, 2'b00, intId};
      OFF_LCR:  regRdData = lineCtrl;
      OFF_MCR:  regRdData = modemCtrl;
      OFF_LSR:  regRdData = {1'b0, 2'b11, 4'b0000, !qEmpty};
      OFF_MSR:  regRdData = 8'h00;
      default:  regRdData = scratch;
    endcase
  end

  assign fifoEnable    = fifoEn;
  assign ierOut        = intEnable;
  assign divisor       = divReg;
  assign rxPushStrobe  = accepted;
  assign rxDrainStrobe = strobes.rdRbr && !accepted && (qCount <= CNT_W'(1));
  assign txWriteStrobe = strobes.wrThr;
  assign iirReadStrobe = strobes.rdIir;

  AST_LOOP_NO_TX: assert property (@(posedge clk) disable iff (rst)
    (strobes.wrThr && loopback && !txValid) |=> !txValid)
    else $error("loopback byte reached transmit handshake"); // R9

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (txValid && !txReady && !strobes.wrThr) |=> (txValid && $stable(txByte)))
    else $error("pending transmit byte lost"); // R9

  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    rxDrainStrobe |=> qEmpty)
    else $error("drain strobe but queue not empty"); // R8
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_regs_pkg::*;
#(
  parameter int QUEUE_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  regAddr,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [7:0]  regWrData,
  output logic [7:0]  regRdData,
  input  logic        rxValid,
  input  logic [7:0]  rxByte,
  input  logic        txReady,
  output logic        txValid,
  output logic [7:0]  txByte,
  input  logic [3:0]  intId,
  output logic        fifoEnable,
  output logic [3:0]  ierOut,
  output logic [15:0] divisor,
  output logic        rxPushStrobe,
  output logic        rxDrainStrobe,
  output logic        txWriteStrobe,
  output logic        iirReadStrobe
);
  regStrobes_t strobes;
  logic        divAccess;

  uart_reg_ctrl ctrl (
    .clk       (clk),
    .rst       (rst),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .divAccess (divAccess),
    .strobes   (strobes)
  );

  uart_reg_datapath #(.QUEUE_DEPTH(QUEUE_DEPTH)) dpath (
    .clk           (clk),
    .rst           (rst),
    .strobes       (strobes),
    .regAddr       (regAddr),
    .regWrData     (regWrData),
    .regRdData     (regRdData),
    .rxValid       (rxValid),
    .rxByte        (rxByte),
    .txReady       (txReady),
    .txValid       (txValid),
    .txByte        (txByte),
    .intId         (intId),
    .divAccess     (divAccess),
    .fifoEnable    (fifoEnable),
    .ierOut        (ierOut),
    .divisor       (divisor),
    .rxPushStrobe  (rxPushStrobe),
    .rxDrainStrobe (rxDrainStrobe),
    .txWriteStrobe (txWriteStrobe),
    .iirReadStrobe (iirReadStrobe)
  );
endmodule

// File: tb/tb_uart_host_regs.sv
`timescale 1ns/1ps
module tb_uart_host_regs;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        rxValid = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        txReady = 1'b0;
  logic        txValid;
  logic [7:0]  txByte;
  logic [3:0]  intId = '0;
  logic        fifoEnable;
  logic [3:0]  ierOut;
  logic [15:0] divisor;
  logic        rxPushStrobe, rxDrainStrobe, txWriteStrobe, iirReadStrobe;

  int total = 0;
  int bad = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [7:0] model[$];

  always #2 clk = ~clk;

  uart_host_regs dut (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData), .rxValid(rxValid), .rxByte(rxByte),
    .txReady(txReady), .txValid(txValid), .txByte(txByte), .intId(intId),
    .fifoEnable(fifoEnable), .ierOut(ierOut), .divisor(divisor),
    .rxPushStrobe(rxPushStrobe), .rxDrainStrobe(rxDrainStrobe),
    .txWriteStrobe(txWriteStrobe), .iirReadStrobe(iirReadStrobe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares read data against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (regRdEn) begin
        if (expQ.size() == 0) chk("scoreboard underflow", 32'd1, 32'd0);
        else chk(tagQ.pop_front(), {24'd0, regRdData}, {24'd0, expQ.pop_front()});
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    expQ.push_back(e); tagQ.push_back(tag);
    regAddr = a; regRdEn = 1'b1;
    @(posedge clk); #1;
    regRdEn = 1'b0;
  endtask

  // data read predicted from the bench byte model, drain strobe checked in-cycle
  task automatic rdData(input string tag);
    logic [7:0] e;
    e = (model.size() == 0) ? 8'h00 : model.pop_front();
    @(negedge clk);
    expQ.push_back(e); tagQ.push_back(tag);
    regAddr = 3'd0; regRdEn = 1'b1;
    #1 chk({tag, " R8 drain strobe"}, {31'd0, rxDrainStrobe}, {31'd0, model.size() == 0});
    @(posedge clk); #1;
    regRdEn = 1'b0;
  endtask

  task automatic rxIn(input logic [7:0] b);
    logic acc;
    acc = (model.size() < 16);
    @(negedge clk);
    rxValid = 1'b1; rxByte = b;
    #1 chk("R5/R7 push strobe", {31'd0, rxPushStrobe}, {31'd0, acc});
    if (acc) model.push_back(b);
    @(posedge clk); #1;
    rxValid = 1'b0;
  endtask

  task automatic wrThr(input logic [7:0] d, input logic loop);
    @(negedge clk);
    regAddr = 3'd0; regWrData = d; regWrEn = 1'b1;
    #1 chk("R9 tx write strobe", {31'd0, txWriteStrobe}, 32'd1);
    if (loop) model.push_back(d);
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  initial begin
    #800000;
    chk("watchdog expired", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset values
    rd(3'd5, 8'h60, "R1 line status");
    rd(3'd3, 8'h00, "R1 line control");
    rd(3'd4, 8'h00, "R1 modem control");
    rd(3'd1, 8'h00, "R1 interrupt enable");
    rd(3'd7, 8'h00, "R1 scratch");
    chk("R1 txValid", {31'd0, txValid}, 32'd0);
    chk("R1 divisor", {16'd0, divisor}, 32'd0);

    // R3 plain registers
    wr(3'd3, 8'h1b); rd(3'd3, 8'h1b, "R3 line control");
    wr(3'd4, 8'h03); rd(3'd4, 8'h03, "R3 modem control");
    wr(3'd7, 8'ha5); rd(3'd7, 8'ha5, "R3 scratch a5");
    wr(3'd7, 8'h5a); rd(3'd7, 8'h5a, "R3 scratch 5a");

    // R4 interrupt enable nibble
    wr(3'd1, 8'hff); rd(3'd1, 8'h0f, "R4 enable readback");
    chk("R4 ierOut", {28'd0, ierOut}, 32'hf);
    wr(3'd1, 8'h05); rd(3'd1, 8'h05, "R4 enable 05");

    // R2 divisor access
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h34); wr(3'd1, 8'h12);
    rd(3'd0, 8'h34, "R2 divisor low");
    rd(3'd1, 8'h12, "R2 divisor high");
    chk("R2 divisor port", {16'd0, divisor}, 32'h1234);
    chk("R2 no transmit", {31'd0, txValid}, 32'd0);
    wr(3'd3, 8'h03);
    rd(3'd1, 8'h05, "R2 enable untouched");
    rd(3'd5, 8'h60, "R2 queue untouched");

    // R5/R6 receive order
    rxIn(8'h11); rxIn(8'h22); rxIn(8'h33);
    rd(3'd5, 8'h61, "R5 data ready");
    rdData("R6 byte 1"); rdData("R6 byte 2"); rdData("R6 byte 3");
    rd(3'd5, 8'h60, "R8 data ready cleared");

    // R7 overflow
    for (int i = 0; i < 17; i++) rxIn(8'(8'h40 + i));
    rd(3'd5, 8'h61, "R7 full data ready");
    for (int i = 0; i < 16; i++) rdData("R7 queued byte");
    rdData("R8 empty read");
    rd(3'd5, 8'h60, "R8 still empty");

    // R9 transmit handshake
    wrThr(8'h41, 1'b0);
    chk("R9 txValid set", {31'd0, txValid}, 32'd1);
    chk("R9 txByte", {24'd0, txByte}, 32'h41);
    repeat (3) @(posedge clk);
    #1 chk("R9 held without ready", {31'd0, txValid}, 32'd1);
    rd(3'd5, 8'h60, "R9 no local echo");
    @(negedge clk) txReady = 1'b1;
    @(posedge clk); #1 txReady = 1'b0;
    chk("R9 txValid cleared", {31'd0, txValid}, 32'd0);

    // R9 loopback
    wr(3'd4, 8'h10);
    wrThr(8'h77, 1'b1);
    chk("R9 loopback no tx", {31'd0, txValid}, 32'd0);
    rd(3'd5, 8'h61, "R9 loopback data ready");
    rdData("R9 loopback byte");
    wr(3'd4, 8'h00);

    // R10 ignored writes
    wr(3'd5, 8'hff); rd(3'd5, 8'h60, "R10 line status write ignored");
    wr(3'd6, 8'hff); rd(3'd6, 8'h00, "R10 offset 6 reads zero");

    // R11 identification
    intId = 4'h2;
    rd(3'd2, 8'h02, "R11 id no fifo");
    wr(3'd2, 8'h01);
    chk("R11 fifoEnable", {31'd0, fifoEnable}, 32'd1);
    intId = 4'hc;
    @(negedge clk);
    expQ.push_back(8'hcc); tagQ.push_back("R11 id fifo on");
    regAddr = 3'd2; regRdEn = 1'b1;
    #1 chk("R11 read strobe", {31'd0, iirReadStrobe}, 32'd1);
    @(posedge clk); #1 regRdEn = 1'b0;
    wr(3'd2, 8'h00);
    rd(3'd2, 8'h0c, "R11 id fifo off");

    @(negedge clk); #2;
    chk("scoreboard drained", expQ.size(), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule